// File: doc/BRIEF.md
# March Test Memory Self-Test Sequencer

This block runs a march test on a single-port synchronous RAM. Five algorithms are built in and one is picked when a test starts: a plain scan of 4n operations, two short march tests of 5n and 6n operations, a 10n march, and a 49n hammer test. The hammer test writes the inverted value ten times in a row to each cell. Each algorithm is a fixed list of elements. An element walks every address either upward or downward, and at each cell it issues a short list of reads and writes, one per clock.

The sequencer drives the RAM address, enable, write enable and write data. The data word is written as all zeros or all ones. The RAM answers a read one cycle later. The expected bit rides along with the read in a pipeline register, so each returned word is compared in full against the expected background on the following cycle. The first mismatch is latched together with its address and element index. When the test ends, `done` rises and stays high, and `pass` or `fail` gives the verdict.

Top module: `mbist_top`

## Requirements
- R1: During and after reset, `busy`, `done`, `pass`, `fail`, `memEn` and `memWe` are all low.
- R2: `start` is accepted only when no test is running, that is while idle or with `done` high. A `start` pulse during a running test has no effect on the issued operations or on the verdict.
- R3: `algoSel` = 0 runs the scan test, 4n operations in four upward elements: write 0, read 0, write 1, read 1.
- R4: `algoSel` = 1 runs the 5n test: upward write 0, then upward (read 0, write 1), then downward (read 1, write 0).
- R5: `algoSel` = 2 runs the 6n test. It is the 5n test with its final downward element extended to (read 1, write 0, read 0).
- R6: `algoSel` = 3 runs the 10n test: write 0; up (r0,w1); up (r1,w0); down (r0,w1); down (r1,w0); read 0. The first and last elements run upward.
- R7: `algoSel` = 4 runs the 49n hammer test: upward write 0, then four elements (up, up, down, down). Each of the four reads the old value b, writes ~b ten times and reads ~b, with b being 0, 1, 0, 1 in that order. Values 5 to 7 run the scan test.
- R8: Operations are issued one per clock from the cycle after `start` is accepted. All operations of an element hit one cell before the address moves. Upward walks run 0 to 2^AW-1 and downward walks run 2^AW-1 to 0.
- R9: A write puts the value bit on every data bit. A read is compared over the full word against the expected value, using the RAM data of the following cycle.
- R10: The first mismatching read sets `fail` and captures `failAddr` and `failElem`, where the element index counts from 0 in algorithm order. Later mismatches change nothing. An accepted `start` clears all three.
- R11: `done` rises in the second cycle after the last operation and stays high until the next accepted `start`. `pass` is high exactly when `done` is high and `fail` is low.
- R12: `memEn` and `memWe` are low whenever no operation is issued. This includes the single drain cycle after the last operation, during which `busy` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test when not running |
| algoSel | input | 3 | Algorithm choice, sampled with start |
| memRdata | input | DW | RAM read data, one cycle after the read |
| memAddr | output | AW | RAM address |
| memEn | output | 1 | RAM access strobe |
| memWe | output | 1 | RAM write enable |
| memWdata | output | DW | RAM write data |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | Finished without mismatch |
| fail | output | 1 | A mismatch was seen |
| failAddr | output | AW | Address of first mismatch |
| failElem | output | 3 | Element index of first mismatch |

## Verification
Each algorithm first runs against a fault-free RAM model. This separates the five operation tables, together with their lengths and walk directions, cycle by cycle. It also shows that an out-of-range select falls back to the scan test. A stuck-at-one bit placed mid-array catches a scan test that fails to compare its first read. A stuck-at-zero bit at the top address catches a 6n test whose downward walk starts at the wrong end. A cell that cannot rise from 0 to 1 must be caught on the first read of ones in the 10n and hammer tests, so a wrong element index or a second latch would show up. A clean run after a failing one shows that start clears the verdict, and a start pulse in the middle of a hammer run must leave the operation stream untouched.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef struct packed {
    logic isWrite;
    logic val;
  } marchOp_t;

  typedef struct packed {
    logic       clrFail;
    logic       addrInit;
    logic       initDesc;
    logic       addrStep;
    logic       issue;
    logic       isWrite;
    logic       val;
    logic [2:0] elem;
  } ctrlStrobe_t;

  function automatic logic [2:0] algoOf(input logic [2:0] sel);
    return (sel > 3'd4) ? 3'd0 : sel;
  endfunction

  function automatic logic [2:0] elemCount(input logic [2:0] a);
    case (a)
      3'd1, 3'd2: return 3'd3;
      3'd3:       return 3'd6;
      3'd4:       return 3'd5;
      default:    return 3'd4;
    endcase
  endfunction

  function automatic logic elemDesc(input logic [2:0] a, input logic [2:0] e);
    case (a)
      3'd1, 3'd2: return e == 3'd2;
      3'd3, 3'd4: return (e == 3'd3) || (e == 3'd4);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] elemLen(input logic [2:0] a, input logic [2:0] e);
    case (a)
      3'd1:    return (e == 3'd0) ? 4'd1 : 4'd2;
      3'd2:    return (e == 3'd0) ? 4'd1 : ((e == 3'd1) ? 4'd2 : 4'd3);
      3'd3:    return (e == 3'd0 || e == 3'd5) ? 4'd1 : 4'd2;
      3'd4:    return (e == 3'd0) ? 4'd1 : 4'd12;
      default: return 4'd1;
    endcase
  endfunction

  function automatic marchOp_t opAt(input logic [2:0] a, input logic [2:0] e,
                                    input logic [3:0] i);
    marchOp_t op;
    logic     base;
    op   = '0;
    base = (e == 3'd2) || (e == 3'd4);
    case (a)
      3'd1, 3'd2: begin
        if (e == 3'd0)      op = '{isWrite: 1'b1, val: 1'b0};
        else if (e == 3'd1) op = '{isWrite: (i == 4'd1), val: (i == 4'd1)};
        else                op = '{isWrite: (i == 4'd1), val: (i == 4'd0)};
      end
      3'd3: begin
        if (e == 3'd0)      op = '{isWrite: 1'b1, val: 1'b0};
        else if (e == 3'd5) op = '{isWrite: 1'b0, val: 1'b0};
        else if (i == 4'd0) op = '{isWrite: 1'b0, val: base};
        else                op = '{isWrite: 1'b1, val: ~base};
      end
      3'd4: begin
        if (e == 3'd0)      op = '{isWrite: 1'b1, val: 1'b0};
        else if (i == 4'd0) op = '{isWrite: 1'b0, val: base};
        else if (i == 4'd11) op = '{isWrite: 1'b0, val: ~base};
        else                op = '{isWrite: 1'b1, val: ~base};
      end
      default: op = '{isWrite: (e == 3'd0 || e == 3'd2), val: (e >= 3'd2)};
    endcase
    return op;
  endfunction

endpackage

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  algoSel,
  input  logic        lastAddr,
  output ctrlStrobe_t stb,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_t;

  state_t     state;
  logic [2:0] algo;
  logic [2:0] elem;
  logic [3:0] opIdx;
  marchOp_t   curOp;
  logic       lastOp;
  logic       lastElem;
  logic       canStart;

  assign canStart = (state == S_IDLE) || (state == S_DONE);
  assign busy     = (state == S_RUN) || (state == S_DRAIN);
  assign done     = (state == S_DONE);

  always_comb begin
    curOp    = opAt(algo, elem, opIdx);
    lastOp   = (opIdx == (elemLen(algo, elem) - 4'd1));
    lastElem = (elem == (elemCount(algo) - 3'd1));
    stb      = '0;
    if (canStart && start) begin
      stb.clrFail  = 1'b1;
      stb.addrInit = 1'b1;
      stb.initDesc = elemDesc(algoOf(algoSel), 3'd0);
    end else if (state == S_RUN) begin
      stb.issue   = 1'b1;
      stb.isWrite = curOp.isWrite;
      stb.val     = curOp.val;
      stb.elem    = elem;
      if (lastOp) begin
        if (!lastAddr) begin
          stb.addrStep = 1'b1;
        end else if (!lastElem) begin
          stb.addrInit = 1'b1;
          stb.initDesc = elemDesc(algo, elem + 3'd1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      algo  <= '0;
      elem  <= '0;
      opIdx <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          algo  <= algoOf(algoSel);
          elem  <= '0;
          opIdx <= '0;
          state <= S_RUN;
        end
        S_RUN: begin
          if (lastOp) begin
            opIdx <= '0;
            if (lastAddr) begin
              if (lastElem) state <= S_DRAIN;
              else          elem  <= elem + 3'd1;
            end
          end else begin
            opIdx <= opIdx + 4'd1;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

endmodule

// File: rtl/mbist_datapath.sv
module mbist_datapath
  import mbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   stb,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memEn,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  output logic          lastAddr,
  output logic          fail,
  output logic [AW-1:0] failAddr,
  output logic [2:0]    failElem
);

  localparam logic [AW-1:0] ADDR_TOP = '1;

  logic [AW-1:0] addr;
  logic          dirDesc;
  logic          rdValid;
  logic          rdExp;
  logic [AW-1:0] rdAddr;
  logic [2:0]    rdElem;
  logic [DW-1:0] laneBad;
  logic          cmpBad;

  assign memAddr  = addr;
  assign memEn    = stb.issue;
  assign memWe    = stb.issue & stb.isWrite;
  assign memWdata = {DW{stb.val}};
  assign lastAddr = dirDesc ? (addr == '0) : (addr == ADDR_TOP);

  for (genvar g = 0; g < DW; g++) begin : gLane
    assign laneBad[g] = memRdata[g] ^ rdExp;
  end
  assign cmpBad = rdValid & (|laneBad);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      dirDesc <= 1'b0;
    end else if (stb.addrInit) begin
      addr    <= stb.initDesc ? ADDR_TOP : '0;
      dirDesc <= stb.initDesc;
    end else if (stb.addrStep) begin
      addr <= dirDesc ? addr - 1'b1 : addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdExp   <= 1'b0;
      rdAddr  <= '0;
      rdElem  <= '0;
    end else begin
      rdValid <= stb.issue & ~stb.isWrite;
      rdExp   <= stb.val;
      rdAddr  <= addr;
      rdElem  <= stb.elem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrFail) begin
      fail     <= 1'b0;
      failAddr <= '0;
      failElem <= '0;
    end else if (cmpBad && !fail) begin
      fail     <= 1'b1;
      failAddr <= rdAddr;
      failElem <= rdElem;
    end
  end

endmodule

// File: rtl/mbist_top.sv
module mbist_top
  import mbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    algoSel,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memEn,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] failAddr,
  output logic [2:0]    failElem
);

  ctrlStrobe_t stb;
  logic        lastAddr;

  mbist_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .algoSel  (algoSel),
    .lastAddr (lastAddr),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  mbist_datapath #(.AW(AW), .DW(DW)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memEn    (memEn),
    .memWe    (memWe),
    .memWdata (memWdata),
    .lastAddr (lastAddr),
    .fail     (fail),
    .failAddr (failAddr),
    .failElem (failElem)
  );

  assign pass = done & ~fail;

endmodule

// File: rtl/mbist_chk.sv
module mbist_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          memEn,
  input logic          memWe,
  input logic [AW-1:0] failAddr,
  input logic [2:0]    failElem
);

  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R11

  AST_END_INTO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R11

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> (fail && $stable(failAddr) && $stable(failElem))); // R10

  AST_WRITE_IN_OP: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memEn && busy)); // R12

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn); // R12

endmodule

bind mbist_top mbist_chk #(.AW(AW)) uChk (.*);

// File: tb/mbist_top_test.sv
`timescale 1ns/1ps
module mbist_top_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, start;
  logic [2:0]    algoSel;
  logic [DW-1:0] memRdata;
  logic [AW-1:0] memAddr;
  logic          memEn, memWe, busy, done, pass, fail;
  logic [DW-1:0] memWdata;
  logic [AW-1:0] failAddr;
  logic [2:0]    failElem;

  mbist_top #(.AW(AW), .DW(DW)) uut (.*);

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  bit saEn = 0, saVal = 0, tfEn = 0;
  int saAddr = 0, saBit = 0, tfAddr = 0, tfBit = 0;

  logic [DW-1:0] ram [N];
  logic [DW-1:0] refMem [N];

  function automatic logic [DW-1:0] rdFault(logic [DW-1:0] d, int a);
    if (saEn && a == saAddr) d[saBit] = saVal;
    return d;
  endfunction

  function automatic logic [DW-1:0] wrFault(logic [DW-1:0] old, logic [DW-1:0] nw, int a);
    if (tfEn && a == tfAddr && !old[tfBit]) nw[tfBit] = 1'b0;
    return nw;
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr] <= wrFault(ram[memAddr], memWdata, int'(memAddr));
      else       memRdata     <= rdFault(ram[memAddr], int'(memAddr));
    end
  end

  int qAddr[$];
  bit qWe[$];
  bit qVal[$];
  bit expFail;
  int expAddr, expElem;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic addElem(bit desc, string ops, int e);
    for (int k = 0; k < N; k++) begin
      int a;
      a = desc ? N - 1 - k : k;
      for (int j = 0; j < ops.len(); j += 2) begin
        bit w, v;
        w = (ops[j] == "w");
        v = (ops[j+1] == "1");
        qAddr.push_back(a);
        qWe.push_back(w);
        qVal.push_back(v);
        if (w) refMem[a] = wrFault(refMem[a], {DW{v}}, a);
        else if (!expFail && rdFault(refMem[a], a) != {DW{v}}) begin
          expFail = 1; expAddr = a; expElem = e;
        end
      end
    end
  endtask

  task automatic buildAlgo(int sel);
    string h1, h2;
    qAddr.delete(); qWe.delete(); qVal.delete();
    expFail = 0; expAddr = 0; expElem = 0;
    for (int i = 0; i < N; i++) refMem[i] = ram[i];
    h1 = "r0"; h2 = "r1";
    for (int i = 0; i < 10; i++) begin h1 = {h1, "w1"}; h2 = {h2, "w0"}; end
    h1 = {h1, "r1"}; h2 = {h2, "r0"};
    case (sel)
      1: begin addElem(0, "w0", 0); addElem(0, "r0w1", 1); addElem(1, "r1w0", 2); end
      2: begin addElem(0, "w0", 0); addElem(0, "r0w1", 1); addElem(1, "r1w0r0", 2); end
      3: begin
        addElem(0, "w0", 0); addElem(0, "r0w1", 1); addElem(0, "r1w0", 2);
        addElem(1, "r0w1", 3); addElem(1, "r1w0", 4); addElem(0, "r0", 5);
      end
      4: begin
        addElem(0, "w0", 0); addElem(0, h1, 1); addElem(0, h2, 2);
        addElem(1, h1, 3); addElem(1, h2, 4);
      end
      default: begin
        addElem(0, "w0", 0); addElem(0, "r0", 1); addElem(0, "w1", 2); addElem(0, "r1", 3);
      end
    endcase
  endtask

  task automatic runTest(int sel, int k, string req, bit midStart);
    int bad;
    buildAlgo(sel);
    check(qAddr.size() == k * N, req, "reference op count", qAddr.size(), k * N);
    @(negedge clk); algoSel = 3'(sel); start = 1'b1;
    @(posedge clk);
    bad = 0;
    for (int i = 0; i < qAddr.size(); i++) begin
      @(negedge clk);
      start = midStart && (i == 20);
      if (!(memEn && busy && int'(memAddr) == qAddr[i] && memWe == qWe[i] &&
            memWdata == {DW{qVal[i]}})) bad++;
    end
    check(bad == 0, {req, " R8 R9"}, "op stream mismatching cycles", bad, 0);
    @(negedge clk); start = 1'b0;
    check(busy && !memEn && !memWe && !done, "R12", "drain cycle {busy,memEn,done}",
          {busy, memEn, done}, 4);
    @(negedge clk);
    check(done && !busy, "R11", "done after drain {done,busy}", {done, busy}, 2);
    check(fail == expFail, "R10", "fail flag", fail, expFail);
    if (expFail)
      check(int'(failAddr) == expAddr && int'(failElem) == expElem, "R10",
            "first failure addr*8+elem", failAddr * 8 + failElem, expAddr * 8 + expElem);
    check(pass == !expFail, "R11", "pass flag", pass, !expFail);
    repeat (3) @(negedge clk);
    check(done && pass == !expFail, "R11", "done and verdict held", done, 1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) ram[i] = '0;
    rstN = 1'b0; start = 1'b0; algoSel = '0;
    repeat (3) @(negedge clk);
    check({busy, done, pass, fail, memEn, memWe} == 6'b0, "R1", "reset outputs",
          {busy, done, pass, fail, memEn, memWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memEn, "R1", "idle after reset", {busy, done, memEn}, 0);

    runTest(0, 4, "R3", 0);
    runTest(1, 5, "R4", 0);
    runTest(2, 6, "R5", 0);
    runTest(3, 10, "R6", 0);
    runTest(4, 49, "R7 R2", 1);
    runTest(5, 4, "R7", 0);

    saEn = 1; saAddr = 5; saBit = 3; saVal = 1;
    runTest(0, 4, "R3 R10", 0);
    saAddr = 15; saBit = 7; saVal = 0;
    runTest(2, 6, "R5 R10", 0);
    saEn = 0;

    tfEn = 1; tfAddr = 9; tfBit = 0;
    runTest(3, 10, "R6 R10", 0);
    runTest(4, 49, "R7 R10", 0);
    tfEn = 0;

    runTest(1, 5, "R4 R10", 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule